// File: doc/BRIEF.md
# Two-Cycle Cache Fill Controller

This block sits between a pair of caches, one serving instruction fetch and one serving loads, and a main memory whose reads take two clock cycles. When a cache misses it raises a fill request with the missing address and holds it. The controller picks one request, starts the memory read, and one cycle later hands the returned word to the cache that asked. It tracks a single fill at a time. The state it keeps is a busy flag, the address being filled and which cache the fill is for.

While a request is waiting or being served, the controller tells the pipeline to hold. An instruction miss freezes the fetch stage. A load miss freezes the memory stage and everything upstream of it, and it sends an empty slot to write-back. In the busy cycle the word coming back from memory is forwarded straight to the requester. That is why no stall is raised in that cycle. Write-backs from the data cache go to memory in the cycle they are issued and never occupy the controller.

Top module: `cache_fill_ctrl`

## Requirements
- R1: When the controller is idle and a request is present, `mem_rd_en` is 1 in that same cycle, with `mem_rd_addr` set to the granted address. In the following cycle (the busy cycle) `fill_valid` is 1, `fill_addr` holds that address, and `fill_data` equals `mem_rd_data` of the busy cycle.
- R2: At most one fill is outstanding. `mem_rd_en` is 0 in the busy cycle, and requests seen in the busy cycle start nothing and change no fill output.
- R3: When both `dreq` and `ireq` are 1 in an idle cycle, the data request is granted. `fill_is_data` is 1 for a data-cache fill and 0 for an instruction-cache fill.
- R4: A request that loses arbitration and stays asserted is granted two cycles later, in the cycle right after the winning fill's busy cycle.
- R5: A write-back drives `mem_wr_en`, `mem_wr_addr` and `mem_wr_data` equal to `wb_valid`, `wb_addr` and `wb_data` in the same cycle. On its own it never raises `mem_rd_en` and never produces `fill_valid` in the next cycle.
- R6: `fetch_stall` equals `ireq`, except in the busy cycle of an instruction fill, when it is 0.
- R7: `mem_stall` and `wb_bubble` both equal `dreq`, except in the busy cycle of a data fill, when they are 0.
- R8: While `rst_n` is 0, every stall output, `mem_rd_en`, `mem_wr_en` and `fill_valid` are 0. The first cycle after reset is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dreq | input | 1 | Data cache fill request, held until served |
| daddr | input | ADDR_W | Data cache miss address |
| ireq | input | 1 | Instruction cache fill request, held until served |
| iaddr | input | ADDR_W | Instruction cache miss address |
| wb_valid | input | 1 | Write-back from the data cache |
| wb_addr | input | ADDR_W | Write-back address |
| wb_data | input | DATA_W | Write-back data |
| mem_rd_en | output | 1 | Start of a memory read (initiating cycle) |
| mem_rd_addr | output | ADDR_W | Memory read address |
| mem_rd_data | input | DATA_W | Memory read word, valid in the busy cycle |
| mem_wr_en | output | 1 | Memory write enable |
| mem_wr_addr | output | ADDR_W | Memory write address |
| mem_wr_data | output | DATA_W | Memory write data |
| fill_valid | output | 1 | Fill word delivered this cycle |
| fill_is_data | output | 1 | 1: fill goes to the data cache, 0: to the instruction cache |
| fill_addr | output | ADDR_W | Address of the delivered fill |
| fill_data | output | DATA_W | Forwarded memory word |
| fetch_stall | output | 1 | Hold the fetch stage |
| mem_stall | output | 1 | Hold the memory stage and all stages upstream |
| wb_bubble | output | 1 | Send an empty slot to write-back |

## Verification
The hardest case to produce at the ports is a collision. Both caches have to miss in the same idle cycle, and the instruction request then has to stay up through the data fill's busy cycle and be granted in the cycle after. While this happens, an unrelated write-back and a changing memory word must not disturb the fill in flight. The stimulus follows the hold-until-served protocol: each request is raised at random and dropped only once its own fill has been delivered. Directed phases force simultaneous misses, write-backs with no request, and back-to-back requests. A cycle-by-cycle reference model checks every output.

// File: rtl/fill_pkg.sv
// Shared definitions for the cache fill controller.
// Assumes: nothing beyond IEEE 1800-2017.
package fill_pkg;
    // Which cache a fill belongs to; the encoding matches the fill_is_data port.
    typedef enum logic {
        FILL_ICACHE = 1'b0,
        FILL_DCACHE = 1'b1
    } fill_tgt_e;
endpackage

// File: rtl/fill_arbiter.sv
// Fixed-priority arbiter for fill requests: the data cache beats the
// instruction cache. It grants only while the tracker is idle.
// Assumes: requesters hold their request and address until served.
module fill_arbiter
    import fill_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              dreq,
    input  logic [ADDR_W-1:0] daddr,
    input  logic              ireq,
    input  logic [ADDR_W-1:0] iaddr,
    output logic              start,
    output fill_tgt_e         start_tgt,
    output logic [ADDR_W-1:0] start_addr
);
    logic win_d;
    logic win_i;

    // Grant decision: the data request takes precedence, and nothing is granted while busy or in reset.
    always_comb begin
        win_d      = rst_n && !busy && dreq;
        win_i      = rst_n && !busy && ireq && !dreq;
        start      = win_d || win_i;
        start_tgt  = win_d ? FILL_DCACHE : FILL_ICACHE;
        start_addr = win_d ? daddr : iaddr;
    end

    // R3: a collision in an idle cycle goes to the data cache
    p_data_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dreq && ireq && !busy) |-> (start && start_tgt == FILL_DCACHE && start_addr == daddr));

    // R2: no new grant while a fill is outstanding
    p_no_grant_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start);
endmodule

// File: rtl/fill_tracker.sv
// Holds the state of the one outstanding fill: busy flag, target cache and
// address. A fill is busy for exactly one cycle after its initiating cycle.
// Assumes: start is never raised while busy (the arbiter guarantees it).
module fill_tracker
    import fill_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  fill_tgt_e         start_tgt,
    input  logic [ADDR_W-1:0] start_addr,
    output logic              busy,
    output fill_tgt_e         cur_tgt,
    output logic [ADDR_W-1:0] cur_addr
);
    // Capture a new fill on start; busy falls after its single busy cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            cur_tgt  <= FILL_ICACHE;
            cur_addr <= '0;
        end else begin
            busy <= start;
            if (start) begin
                cur_tgt  <= start_tgt;
                cur_addr <= start_addr;
            end
        end
    end

    // R1: an initiating cycle is always followed by a busy cycle for the same address
    p_init_then_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && cur_addr == $past(start_addr) && cur_tgt == $past(start_tgt)));

    // R2: the busy phase lasts a single cycle
    p_busy_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);
endmodule

// File: rtl/fill_stall_gen.sv
// Derives the pipeline hold signals from pending requests and the fill in
// its busy cycle. A requester is released in the busy cycle of its own fill
// because the memory word is forwarded in that cycle.
// Assumes: the caller gates with reset through rst_n.
module fill_stall_gen
    import fill_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      dreq,
    input  logic      ireq,
    input  logic      busy,
    input  fill_tgt_e cur_tgt,
    output logic      fetch_stall,
    output logic      mem_stall,
    output logic      wb_bubble
);
    logic serve_i;
    logic serve_d;

    // Hold each stage while its request is pending and not being served this cycle.
    always_comb begin
        serve_i     = busy && (cur_tgt == FILL_ICACHE);
        serve_d     = busy && (cur_tgt == FILL_DCACHE);
        fetch_stall = rst_n && ireq && !serve_i;
        mem_stall   = rst_n && dreq && !serve_d;
        wb_bubble   = mem_stall;
    end

    // R6: an instruction request with no instruction fill delivered keeps fetch frozen
    p_fetch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ireq && !busy) |-> fetch_stall);

    // R7: the write-back bubble accompanies every memory-stage hold
    p_bubble_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_stall |-> wb_bubble);
endmodule

// File: rtl/cache_fill_ctrl.sv
// Cache fill controller: arbitrates instruction and data cache refills onto
// a two-cycle-read main memory, forwards the returned word in the busy
// cycle, raises pipeline stalls, and passes write-backs straight through.
// Assumes: each requester holds its request and address until it sees
// fill_valid for its own cache; memory returns read data in the busy cycle.
module cache_fill_ctrl
    import fill_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dreq,
    input  logic [ADDR_W-1:0] daddr,
    input  logic              ireq,
    input  logic [ADDR_W-1:0] iaddr,
    input  logic              wb_valid,
    input  logic [ADDR_W-1:0] wb_addr,
    input  logic [DATA_W-1:0] wb_data,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    output logic              fill_valid,
    output logic              fill_is_data,
    output logic [ADDR_W-1:0] fill_addr,
    output logic [DATA_W-1:0] fill_data,
    output logic              fetch_stall,
    output logic              mem_stall,
    output logic              wb_bubble
);
    logic              busy;
    logic              start;
    fill_tgt_e         start_tgt;
    logic [ADDR_W-1:0] start_addr;
    fill_tgt_e         cur_tgt;
    logic [ADDR_W-1:0] cur_addr;

    fill_arbiter #(.ADDR_W(ADDR_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .busy(busy),
        .dreq(dreq), .daddr(daddr), .ireq(ireq), .iaddr(iaddr),
        .start(start), .start_tgt(start_tgt), .start_addr(start_addr)
    );

    fill_tracker #(.ADDR_W(ADDR_W)) u_trk (
        .clk(clk), .rst_n(rst_n), .start(start), .start_tgt(start_tgt),
        .start_addr(start_addr), .busy(busy), .cur_tgt(cur_tgt), .cur_addr(cur_addr)
    );

    fill_stall_gen u_stall (
        .clk(clk), .rst_n(rst_n), .dreq(dreq), .ireq(ireq),
        .busy(busy), .cur_tgt(cur_tgt),
        .fetch_stall(fetch_stall), .mem_stall(mem_stall), .wb_bubble(wb_bubble)
    );

    // Memory read launch in the initiating cycle.
    always_comb begin
        mem_rd_en   = start;
        mem_rd_addr = start_addr;
    end

    // Write-back pass-through: completes in the issuing cycle, outside the fill state.
    always_comb begin
        mem_wr_en   = rst_n && wb_valid;
        mem_wr_addr = wb_addr;
        mem_wr_data = wb_data;
    end

    // Delivery in the busy cycle with the memory word forwarded to the requester.
    always_comb begin
        fill_valid   = rst_n && busy;
        fill_is_data = (cur_tgt == FILL_DCACHE);
        fill_addr    = cur_addr;
        fill_data    = mem_rd_data;
    end

    // R5: a write-back with no request never starts a fill
    p_wb_no_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !dreq && !ireq) |-> !mem_rd_en);

    // R5: a write-back alone leaves the controller idle in the next cycle
    p_wb_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !mem_rd_en) |=> !fill_valid);

    // R1: a read launch is followed by delivery of that address
    p_launch_delivers_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> (fill_valid && fill_addr == $past(mem_rd_addr)));

    // R8: outputs quiet while reset is held
    p_reset_quiet_r8: assert property (@(posedge clk)
        !rst_n |-> !(fill_valid || mem_rd_en || mem_wr_en || fetch_stall || mem_stall || wb_bubble));
endmodule

// File: tb/test_cache_fill_ctrl.sv
// Bench: reference model of the fill controller driven by hold-until-served
// random requests plus directed collisions, write-backs and reset.
module test_cache_fill_ctrl;
    localparam int AW = 16;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          dreq, ireq, wb_valid;
    logic [AW-1:0] daddr, iaddr, wb_addr;
    logic [DW-1:0] wb_data, mem_rd_data;
    logic          mem_rd_en, mem_wr_en, fill_valid, fill_is_data;
    logic [AW-1:0] mem_rd_addr, mem_wr_addr, fill_addr;
    logic [DW-1:0] mem_wr_data, fill_data;
    logic          fetch_stall, mem_stall, wb_bubble;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    // reference model state
    logic          m_busy;
    logic          m_tgt_d;
    logic [AW-1:0] m_addr;

    always #2 clk = ~clk;

    cache_fill_ctrl #(.ADDR_W(AW), .DATA_W(DW)) i_cache_fill_ctrl (
        .clk(clk), .rst_n(rst_n), .dreq(dreq), .daddr(daddr), .ireq(ireq), .iaddr(iaddr),
        .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .fill_valid(fill_valid), .fill_is_data(fill_is_data), .fill_addr(fill_addr),
        .fill_data(fill_data), .fetch_stall(fetch_stall), .mem_stall(mem_stall),
        .wb_bubble(wb_bubble)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cycles);
        end
    endtask

    function automatic logic exp_stall(input logic req, input logic served);
        return rst_n && req && !served;
    endfunction

    // Compare every output against the model for the current inputs, then advance the model.
    task automatic compare_and_step();
        logic          e_rd;
        logic [AW-1:0] e_rd_addr;
        e_rd      = rst_n && !m_busy && (dreq || ireq);
        e_rd_addr = dreq ? daddr : iaddr;
        check("R1/R2 mem_rd_en", 32'(mem_rd_en), 32'(e_rd));
        if (e_rd) check("R3 mem_rd_addr", 32'(mem_rd_addr), 32'(e_rd_addr));
        check("R1 fill_valid", 32'(fill_valid), 32'(rst_n && m_busy));
        if (rst_n && m_busy) begin
            check("R1 fill_addr", 32'(fill_addr), 32'(m_addr));
            check("R1 fill_data", 32'(fill_data), 32'(mem_rd_data));
            check("R3 fill_is_data", 32'(fill_is_data), 32'(m_tgt_d));
        end
        check("R5 mem_wr_en", 32'(mem_wr_en), 32'(rst_n && wb_valid));
        if (rst_n && wb_valid) begin
            check("R5 mem_wr_addr", 32'(mem_wr_addr), 32'(wb_addr));
            check("R5 mem_wr_data", 32'(mem_wr_data), 32'(wb_data));
        end
        check("R6 fetch_stall", 32'(fetch_stall), 32'(exp_stall(ireq, m_busy && !m_tgt_d)));
        check("R7 mem_stall", 32'(mem_stall), 32'(exp_stall(dreq, m_busy && m_tgt_d)));
        check("R7 wb_bubble", 32'(wb_bubble), 32'(exp_stall(dreq, m_busy && m_tgt_d)));
        if (!rst_n) begin
            m_busy = 1'b0;
        end else if (e_rd) begin
            m_busy  = 1'b1;
            m_tgt_d = dreq;
            m_addr  = e_rd_addr;
        end else begin
            m_busy = 1'b0;
        end
    endtask

    // One cycle: inputs are applied after the falling edge, checked 1 ns later.
    task automatic cycle_once();
        @(negedge clk);
        mem_rd_data = DW'($urandom);
        #1;
        compare_and_step();
    endtask

    // A requester drops its request once its own fill has been seen.
    task automatic retire_served();
        if (fill_valid && fill_is_data)  dreq = 1'b0;
        if (fill_valid && !fill_is_data) ireq = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; dreq = 1'b1; ireq = 1'b1; wb_valid = 1'b1;
        daddr = 16'h00D0; iaddr = 16'h0010; wb_addr = 16'h0BB0; wb_data = 16'hBEEF;
        mem_rd_data = '0;
        m_busy = 1'b0; m_tgt_d = 1'b0; m_addr = '0;

        // R8: reset holds everything quiet even with all requests raised
        repeat (3) cycle_once();
        @(negedge clk); rst_n = 1'b1; dreq = 1'b0; ireq = 1'b0; wb_valid = 1'b0;
        #1 check("R8 idle after reset", {29'd0, fill_valid, mem_stall, fetch_stall}, 32'd0);
        compare_and_step();

        // R3/R4: simultaneous misses, data first, instruction two cycles later
        @(negedge clk); dreq = 1'b1; ireq = 1'b1; daddr = 16'h1234; iaddr = 16'h5678;
        mem_rd_data = 16'h0A0A;
        #1 check("R3 collision grants data address", 32'(mem_rd_addr), 32'h1234);
        compare_and_step();
        @(negedge clk); mem_rd_data = 16'hD00D;
        #1 check("R1 data word forwarded in busy cycle", 32'(fill_data), 32'hD00D);
        compare_and_step(); retire_served();
        @(negedge clk); mem_rd_data = 16'h1111;
        #1 check("R4 loser granted after fill", {15'd0, mem_rd_en, mem_rd_addr}, {15'd0, 1'b1, 16'h5678});
        compare_and_step();
        @(negedge clk); mem_rd_data = 16'h7777;
        #1 check("R6 fetch released in its busy cycle", 32'(fetch_stall), 32'd0);
        compare_and_step(); retire_served();

        // R5: write-back alone
        @(negedge clk); wb_valid = 1'b1; wb_addr = 16'h0420; wb_data = 16'hCAFE;
        #1 check("R5 write-back starts no read", 32'(mem_rd_en), 32'd0);
        compare_and_step();
        @(negedge clk); wb_valid = 1'b0;
        #1 check("R5 no fill after write-back", 32'(fill_valid), 32'd0);
        compare_and_step();

        // R2/R6/R7: random hold-until-served traffic with write-backs
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (!dreq && ($urandom % 4 == 0)) begin dreq = 1'b1; daddr = AW'($urandom); end
            if (!ireq && ($urandom % 3 == 0)) begin ireq = 1'b1; iaddr = AW'($urandom); end
            wb_valid = ($urandom % 3 == 0);
            wb_addr  = AW'($urandom);
            wb_data  = DW'($urandom);
            mem_rd_data = DW'($urandom);
            if (i == 1500) rst_n = 1'b0;
            if (i == 1503) rst_n = 1'b1;
            #1;
            compare_and_step();
            retire_served();
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected <= 20000 cycles", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule